// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Flag and Request Logic

This block turns three single-cycle real-time-clock event strobes into sticky status flags: periodic tick, alarm match and update-ended. It drives one shared active-low interrupt request whenever a flag is pending and its source is enabled. Software reaches it through a small register port. An enable register selects which sources may pull the request line low. A status register shows the pending flags and a summary bit, and every read of it empties all flags in one step.

Each source has a flag state machine with two states, `FLAG_CLEAR` and `FLAG_PENDING`. It takes the *raise* transition from `FLAG_CLEAR` to `FLAG_PENDING` on an event strobe. It takes the *service* transition from `FLAG_PENDING` to `FLAG_CLEAR` on a status read with no coincident event. In `FLAG_PENDING` it takes the *merge* self-transition on a repeat event, or on an event arriving together with a status read. The request line has its own state machine with two states, `LINE_IDLE` and `LINE_ACTIVE`. It takes the *assert* transition when the next-cycle flags and enables have a source in common, and the *release* transition when they share none. This state is loaded from next-cycle values, so the request line changes at the same clock edge as the flags or enables that cause the change.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, all flags and enables are zero, `irq_n` is 1, and reads of the enable register (address 0xB) and the status register (address 0xC) return 0x00.
- R2: An event strobe sets its flag at the next rising edge whatever the enables hold. The flags sit in the status register as follows: periodic in bit 6, alarm in bit 5, update-ended in bit 4.
- R3: From the edge after any change of flags or enables, `irq_n` is 0 exactly when some source has both its flag and its enable set. The enables sit in the enable register as follows: periodic in bit 6, alarm in bit 5, update-ended in bit 4.
- R4: A status read returns the current flags combinationally in the same cycle. At the following edge it clears all three flags together, and `irq_n` is 1 from that edge onward unless a new event arrived.
- R5: Writing an enable register value that drops the enable of every pending source sets `irq_n` to 1 at the write edge. The flags are left as they were.
- R6: A repeat of an event while its flag is pending leaves the flag set and keeps no count. One status read clears it.
- R7: An event strobe in the same cycle as a status read is not lost. That read does not show it, but the flag is set after the clearing edge.
- R8: Status bit 7 is 1 exactly when some flag is set together with its enable. Status bits 3..0 read 0. The enable register reads back bits 6..4 as written, and its other bits read 0.
- R9: Writes to the status address change nothing. A read of any other address returns 0x00 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_periodic | input | 1 | Periodic tick strobe, one cycle |
| evt_alarm | input | 1 | Alarm match strobe, one cycle |
| evt_update | input | 1 | Update-ended strobe, one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the status address clears the flags |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high, 0 otherwise |
| irq_n | output | 1 | Shared interrupt request, active low |

## Verification
The assertions take several things about the inputs for granted. Event strobes and register strobes are synchronous to `clk`. A read of the status address stands for exactly one service per cycle it is held high. No check depends on the address outside a strobe. The stimulus drives every input just after a falling edge and holds each strobe for one cycle only. It reads back through the normal register port one cycle at a time, so each flag-clearing read is a single deliberate service. The exhaustive sweep over all enable masks and all event masks keeps to that single-cycle discipline.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int SRC_N    = 3;
    localparam int DATA_W   = 8;
    localparam int FIELD_LO = 4;
    localparam int SUM_BIT  = 7;

    localparam int SRC_UPDATE   = 0;
    localparam int SRC_ALARM    = 1;
    localparam int SRC_PERIODIC = 2;

    typedef enum logic {
        FLAG_CLEAR,
        FLAG_PENDING
    } flag_state_e;

    typedef enum logic {
        LINE_IDLE,
        LINE_ACTIVE
    } line_state_e;

endpackage

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic clear_i,
    output logic pending_o,
    output logic pending_nx_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    // next-state logic: raise, merge, service
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (event_i) begin
                    state_d = FLAG_PENDING;
                end
            end
            FLAG_PENDING: begin
                if (clear_i && !event_i) begin
                    state_d = FLAG_CLEAR;
                end
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pending_o    = (state_q == FLAG_PENDING);
        pending_nx_o = (state_d == FLAG_PENDING);
    end

endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
    import rtc_irq_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] ENA_ADDR = 4'hB,
    parameter logic [ADDR_W-1:0] STS_ADDR = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SRC_N-1:0]  flags_i,
    output logic [SRC_N-1:0]  en_o,
    output logic [SRC_N-1:0]  en_nx_o,
    output logic              clear_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int FIELD_HI = FIELD_LO + SRC_N - 1;

    logic [SRC_N-1:0] en_q;
    logic [SRC_N-1:0] en_d;
    logic             ena_hit;
    logic             sts_hit;
    logic             unused_wbits;

    assign ena_hit = (addr_i == ENA_ADDR);
    assign sts_hit = (addr_i == STS_ADDR);
    assign unused_wbits = ^{wdata_i[DATA_W-1:FIELD_HI+1], wdata_i[FIELD_LO-1:0]};

    always_comb begin
        en_d = en_q;
        if (wr_i && ena_hit) begin
            en_d = wdata_i[FIELD_HI:FIELD_LO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (ena_hit) begin
                rdata_o[FIELD_HI:FIELD_LO] = en_q;
            end else if (sts_hit) begin
                rdata_o[FIELD_HI:FIELD_LO] = flags_i;
                rdata_o[SUM_BIT]           = |(flags_i & en_q);
            end
        end
    end

    assign clear_o = rd_i && sts_hit;
    assign en_o    = en_q;
    assign en_nx_o = en_d;

endmodule

// File: rtl/rtc_irq_line.sv
module rtc_irq_line
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] flags_nx_i,
    input  logic [SRC_N-1:0] en_nx_i,
    output logic             irq_n_o
);

    line_state_e state_q;
    line_state_e state_d;
    logic        want;

    assign want = |(flags_nx_i & en_nx_i);

    // assert / release transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (want)  state_d = LINE_ACTIVE;
            LINE_ACTIVE: if (!want) state_d = LINE_IDLE;
            default:     state_d = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_n_o = (state_q != LINE_ACTIVE);
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] ENA_ADDR = 4'hB,
    parameter logic [ADDR_W-1:0] STS_ADDR = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_n
);

    logic [SRC_N-1:0] evt_vec;
    logic [SRC_N-1:0] flag_q;
    logic [SRC_N-1:0] flag_nx;
    logic [SRC_N-1:0] en_q;
    logic [SRC_N-1:0] en_nx;
    logic             sts_clear;

    always_comb begin
        evt_vec               = '0;
        evt_vec[SRC_PERIODIC] = evt_periodic;
        evt_vec[SRC_ALARM]    = evt_alarm;
        evt_vec[SRC_UPDATE]   = evt_update;
    end

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        rtc_irq_flag u_flag (
            .clk          (clk),
            .rst_n        (rst_n),
            .event_i      (evt_vec[g]),
            .clear_i      (sts_clear),
            .pending_o    (flag_q[g]),
            .pending_nx_o (flag_nx[g])
        );
    end

    rtc_irq_regs #(
        .ADDR_W   (ADDR_W),
        .ENA_ADDR (ENA_ADDR),
        .STS_ADDR (STS_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .rd_i    (reg_rd),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .flags_i (flag_q),
        .en_o    (en_q),
        .en_nx_o (en_nx),
        .clear_o (sts_clear),
        .rdata_o (reg_rdata)
    );

    rtc_irq_line u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_nx_i (flag_nx),
        .en_nx_i    (en_nx),
        .irq_n_o    (irq_n)
    );

endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk
    import rtc_irq_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] STS_ADDR = 4'hC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_periodic,
    input logic              evt_alarm,
    input logic              evt_update,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              irq_n,
    input logic [SRC_N-1:0]  flags,
    input logic [SRC_N-1:0]  en
);

    logic any_evt;
    logic sts_rd;
    assign any_evt = evt_periodic | evt_alarm | evt_update;
    assign sts_rd  = reg_rd && (reg_addr == STS_ADDR);

    a_r2_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_alarm |=> flags[SRC_ALARM]);

    a_r3_line_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(|(flags & en)));

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !any_evt) |=> (flags == '0 && irq_n));

    a_r5_mask_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == 4'hB && reg_wdata[6:4] == 3'b000) |=> irq_n);

    a_r6_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[SRC_PERIODIC] && !sts_rd) |=> flags[SRC_PERIODIC]);

    a_r7_coincident_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && evt_update) |=> flags[SRC_UPDATE]);

    a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3:0] == 4'h0);

    a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == 8'h00);

endmodule

bind rtc_irq_ctrl rtc_irq_chk #(.ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_periodic (evt_periodic),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_n        (irq_n),
    .flags        (flag_q),
    .en           (en_q)
);

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_ENA = 4'hB;
    localparam logic [3:0] A_STS = 4'hC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_periodic = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_update = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // events mask: bit2 periodic, bit1 alarm, bit0 update
    task automatic pulse(input logic [2:0] m);
        {evt_periodic, evt_alarm, evt_update} = m;
        @(negedge clk);
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [2:0] m,
                      input logic [7:0] exp, input string req);
        reg_rd = 1'b1; reg_addr = a;
        {evt_periodic, evt_alarm, evt_update} = m;
        #1;
        check(req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    function automatic logic [7:0] sts_val(input logic [2:0] f, input logic [2:0] e);
        return {(|(f & e)), f, 4'b0000};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);
        rd(A_ENA, 3'b000, 8'h00, "R1 enable");
        rd(A_STS, 3'b000, 8'h00, "R1 status");

        // R2 R3 R4 R8 exhaustive sweep over enable mask x event mask
        for (int e = 0; e < 8; e++) begin
            for (int m = 0; m < 8; m++) begin
                wr(A_ENA, {1'b1, 3'(e), 4'hF});
                pulse(3'(m));
                check("R3 irq_n pending", {7'b0, irq_n}, {7'b0, !(|(3'(m) & 3'(e)))});
                rd(A_STS, 3'b000, sts_val(3'(m), 3'(e)), "R2 R8 status");
                check("R4 irq_n after read", {7'b0, irq_n}, 8'h01);
                rd(A_STS, 3'b000, 8'h00, "R4 flags cleared");
            end
        end

        // R8 enable readback
        wr(A_ENA, 8'hFF);
        rd(A_ENA, 3'b000, 8'h70, "R8 enable readback");

        // R6 repeated events merge
        pulse(3'b100);
        pulse(3'b100);
        pulse(3'b100);
        check("R6 irq_n", {7'b0, irq_n}, 8'h00);
        rd(A_STS, 3'b000, 8'hC0, "R6 merged flag");
        rd(A_STS, 3'b000, 8'h00, "R6 one read clears");

        // R7 event coincident with status read
        pulse(3'b010);
        rd(A_STS, 3'b001, 8'hA0, "R7 read shows old flags");
        check("R7 irq_n kept", {7'b0, irq_n}, 8'h00);
        rd(A_STS, 3'b000, 8'h90, "R7 event kept");

        // R5 enable clear releases line, flag stays
        pulse(3'b100);
        check("R5 irq_n before", {7'b0, irq_n}, 8'h00);
        wr(A_ENA, 8'h00);
        check("R5 irq_n released", {7'b0, irq_n}, 8'h01);
        rd(A_STS, 3'b000, 8'h40, "R5 flag retained");

        // R9 status write ignored, other address reads zero without clearing
        wr(A_ENA, 8'h20);
        pulse(3'b010);
        wr(A_STS, 8'h00);
        wr(A_STS, 8'hFF);
        rd(4'h3, 3'b000, 8'h00, "R9 other address");
        check("R9 irq_n", {7'b0, irq_n}, 8'h00);
        rd(A_ENA, 3'b000, 8'h20, "R9 enable untouched");
        rd(A_STS, 3'b000, 8'hA0, "R9 flags untouched");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule